// File: doc/BRIEF.md
# Early-Late Tracking Two-Counter Digital Oscillator

This block is the core of an all-digital phase-locked loop that runs entirely on a fast clock (fc). Two counters are chained. A reloadable down counter divides fc by N. Each time it reaches zero it bumps a divide-by-M up counter. When the up counter is at its last count and the down counter hits zero, the block fires a one-cycle output pulse. The output pulse period is therefore M·N fast-clock cycles.

A reference input is synchronised into the fc domain and halved. The falling edge of the halved reference opens a measurement window. It restarts both counters, so the first output pulse of the window lands exactly M·N cycles after the window opens. The rising edge of the halved reference closes the window, and at that point the block judges the output pulse as early, late or on time. An early pulse means N is too small, so N is raised by one. A late pulse means N is too large, so N is lowered by one. An on-time pulse leaves N alone.

The loop settles when M·N equals the reference period measured in fc cycles. N saturates at both ends of its range. A lock flag reports that N has stopped moving.

Top module: `nm_dco_pll`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted, n_value equals N_INIT (default 16), locked is 0 and v2_out is 0.
- R2: Each rising edge of ref_in, after a two-flop synchroniser, toggles a half-rate reference that starts at 0. Its 1-to-0 toggle is a one-cycle window start. Its 0-to-1 toggle is a comparison. A comparison that comes before the first window start since reset leaves n_value unchanged, and so does every window start.
- R3: A window start loads the divide-by-N counter so that it reaches zero N cycles later. From then on it reaches zero every N cycles, reloading from the current n_value.
- R4: A window start clears the divide-by-M counter to 0. Each zero of the divide-by-N counter advances it by one, and it wraps from M-1 to 0.
- R5: v2_out is a single-cycle pulse, high when the divide-by-M counter is at M-1 and the divide-by-N counter is at zero. While N is constant, consecutive pulses are M·N cycles apart.
- R6: If v2_out pulsed after the window start and before the comparison cycle, the comparison is early and n_value becomes N+1 in the following cycle.
- R7: If v2_out did not pulse in the window, including the comparison cycle itself, the comparison is late and n_value becomes N-1.
- R8: If the only pulse in the window falls in the comparison cycle, n_value is unchanged. For a reference period of P fc cycles this happens exactly when M·N = P.
- R9: n_value never goes above 255 or below 1. An early verdict at 255 and a late verdict at 1 leave it unchanged.
- R10: locked is 1 once four consecutive comparisons have left n_value unchanged, counting saturated ones. Any comparison that changes n_value clears it in the same cycle that n_value changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock fc that drives all counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference square wave, asynchronous to clk |
| v2_out | output | 1 | Single-cycle output pulse, one every M·N cycles |
| n_value | output | N_W | Current divide ratio N |
| locked | output | 1 | N has held steady for LOCK_CNT comparisons |

## Verification
Both saturation rails are the hardest conditions to reach from the ports. From the default start value, reaching 255 would take hundreds of comparison windows, each two reference periods long. Reaching 1 needs a reference period of only a few fast-clock cycles. The stimulus therefore adds two more instances with their start value next to a rail. One of them gets a reference period longer than 2·255 cycles. The other gets a 3-cycle reference, which is shorter than its M·1 output period. Both are driven until the saturated comparisons by themselves raise the lock flag.

// File: rtl/nm_pll_pkg.sv
package nm_pll_pkg;

  typedef enum logic [1:0] {
    CMP_NONE  = 2'd0,
    CMP_EARLY = 2'd1,
    CMP_LATE  = 2'd2,
    CMP_HOLD  = 2'd3
  } cmp_t;

  // An earlier pulse in the window outranks a pulse in the comparison cycle,
  // so a harmonic (M*N = P/2) is still pushed upward.
  function automatic cmp_t judge(input logic seen_before, input logic pulse_now);
    if (seen_before)    return CMP_EARLY;
    else if (pulse_now) return CMP_HOLD;
    else                return CMP_LATE;
  endfunction

  function automatic int unsigned step_n(input int unsigned n, input cmp_t d,
                                         input int unsigned n_max);
    case (d)
      CMP_EARLY: return (n >= n_max) ? n : n + 1;
      CMP_LATE:  return (n <= 1) ? n : n - 1;
      default:   return n;
    endcase
  endfunction

endpackage

// File: rtl/nm_ref_shaper.sv
module nm_ref_shaper #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic start_evt,
  output logic cmp_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic ref_d_q;
  logic half_q;
  logic ref_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      ref_d_q <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], ref_in};
      ref_d_q <= sync_q[SYNC_STAGES-1];
      if (ref_rise) half_q <= ~half_q;
    end
  end

  assign ref_rise  = sync_q[SYNC_STAGES-1] & ~ref_d_q;
  assign start_evt = ref_rise & half_q;
  assign cmp_evt   = ref_rise & ~half_q;
endmodule

// File: rtl/nm_divider.sv
module nm_divider #(
  parameter int N_W    = 8,
  parameter int M_DIV  = 4,
  parameter int N_INIT = 16,
  localparam int M_W   = (M_DIV > 1) ? $clog2(M_DIV) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_evt,
  input  logic [N_W-1:0] n_load,
  output logic           v2,
  output logic [M_W-1:0] m_count
);
  logic [N_W-1:0] n_cnt_q;
  logic [M_W-1:0] m_cnt_q;
  logic           n_tc;
  logic           m_top;

  assign n_tc    = (n_cnt_q == '0);
  assign m_top   = (m_cnt_q == M_W'(M_DIV - 1));
  assign v2      = n_tc & m_top;
  assign m_count = m_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cnt_q <= N_W'(N_INIT - 1);
      m_cnt_q <= '0;
    end else if (start_evt) begin
      n_cnt_q <= n_load - 1'b1;
      m_cnt_q <= '0;
    end else if (n_tc) begin
      n_cnt_q <= n_load - 1'b1;
      m_cnt_q <= m_top ? '0 : m_cnt_q + 1'b1;
    end else begin
      n_cnt_q <= n_cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nm_loop_ctrl.sv
module nm_loop_ctrl
  import nm_pll_pkg::*;
#(
  parameter int N_W      = 8,
  parameter int N_INIT   = 16,
  parameter int LOCK_CNT = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_evt,
  input  logic           cmp_evt,
  input  logic           v2,
  output logic [N_W-1:0] n_value,
  output logic           locked
);
  localparam int unsigned N_MAX = (1 << N_W) - 1;
  localparam int S_W = $clog2(LOCK_CNT + 1);

  logic           seen_q;
  logic           armed_q;
  logic [N_W-1:0] n_q;
  logic [N_W-1:0] n_nxt;
  logic [S_W-1:0] streak_q;
  cmp_t           verdict;

  always_comb begin
    verdict = CMP_NONE;
    if (cmp_evt && armed_q) verdict = judge(seen_q, v2);
    n_nxt = N_W'(step_n(32'(n_q), verdict, N_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q   <= 1'b0;
      armed_q  <= 1'b0;
      n_q      <= N_W'(N_INIT);
      streak_q <= '0;
    end else begin
      if (start_evt)  seen_q <= 1'b0;
      else if (v2)    seen_q <= 1'b1;
      if (start_evt)  armed_q <= 1'b1;
      if (verdict != CMP_NONE) begin
        n_q <= n_nxt;
        if (n_nxt != n_q)                      streak_q <= '0;
        else if (streak_q != S_W'(LOCK_CNT))   streak_q <= streak_q + 1'b1;
      end
    end
  end

  assign n_value = n_q;
  assign locked  = (streak_q == S_W'(LOCK_CNT));
endmodule

// File: rtl/nm_dco_pll.sv
module nm_dco_pll #(
  parameter int N_W         = 8,
  parameter int M_DIV       = 4,
  parameter int N_INIT      = 16,
  parameter int LOCK_CNT    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int M_W        = (M_DIV > 1) ? $clog2(M_DIV) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_in,
  output logic           v2_out,
  output logic [N_W-1:0] n_value,
  output logic           locked
);
  logic           start_evt;
  logic           cmp_evt;
  logic [M_W-1:0] m_count;

  nm_ref_shaper #(.SYNC_STAGES(SYNC_STAGES)) u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_in    (ref_in),
    .start_evt (start_evt),
    .cmp_evt   (cmp_evt)
  );

  nm_divider #(.N_W(N_W), .M_DIV(M_DIV), .N_INIT(N_INIT)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .n_load    (n_value),
    .v2        (v2_out),
    .m_count   (m_count)
  );

  nm_loop_ctrl #(.N_W(N_W), .N_INIT(N_INIT), .LOCK_CNT(LOCK_CNT)) u_loop (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .cmp_evt   (cmp_evt),
    .v2        (v2_out),
    .n_value   (n_value),
    .locked    (locked)
  );
endmodule

// File: rtl/nm_dco_pll_chk.sv
module nm_dco_pll_chk #(
  parameter int N_W = 8,
  parameter int M_W = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_evt,
  input logic           cmp_evt,
  input logic           v2_out,
  input logic [N_W-1:0] n_value,
  input logic           locked,
  input logic [M_W-1:0] m_count
);
  // R2
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && cmp_evt));

  // R2
  n_cmp_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_value) |-> $past(cmp_evt));

  // R4
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (m_count == '0));

  // R5
  v2_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v2_out |=> !v2_out);

  // R6
  n_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_value) |-> (n_value == N_W'($past(n_value) + 1'b1)) ||
                          (n_value == N_W'($past(n_value) - 1'b1)));

  // R9
  n_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_value != '0);

  // R10
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(n_value) |-> !locked);
endmodule

bind nm_dco_pll nm_dco_pll_chk #(.N_W(N_W), .M_W(M_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_evt (start_evt),
  .cmp_evt   (cmp_evt),
  .v2_out    (v2_out),
  .n_value   (n_value),
  .locked    (locked),
  .m_count   (m_count)
);

// File: tb/sim_nm_dco_pll.sv
module sim_nm_dco_pll;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    due;
    int    inst;
    int    n;
    bit    lk;
    string tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  item_t sb[$];

  logic       v2_0, v2_1, v2_2;
  logic [7:0] n0, n1, n2;
  logic       lk0, lk1, lk2;

  nm_dco_pll #(.M_DIV(4), .N_INIT(16)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .v2_out(v2_0), .n_value(n0), .locked(lk0));
  nm_dco_pll #(.M_DIV(2), .N_INIT(254)) u1 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .v2_out(v2_1), .n_value(n1), .locked(lk1));
  nm_dco_pll #(.M_DIV(4), .N_INIT(2)) u2 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .v2_out(v2_2), .n_value(n2), .locked(lk2));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // v2 interval monitor for u0
  int last_v2 = -1;
  int last_gap = 0;
  always @(negedge clk) begin
    if (v2_0) begin
      if (last_v2 >= 0) last_gap = cyc - last_v2;
      last_v2 = cyc;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      int an;
      bit al;
      it = sb.pop_front();
      case (it.inst)
        0:       begin an = n0; al = lk0; end
        1:       begin an = n1; al = lk1; end
        default: begin an = n2; al = lk2; end
      endcase
      check($sformatf("%s n inst%0d", it.tag, it.inst), an, it.n);
      check($sformatf("R10 locked inst%0d", it.inst), int'(al), int'(it.lk));
    end
  end

  task automatic do_reset();
    @(negedge clk);
    ref_in = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 n_value", n0, 16);
    check("R1 locked", int'(lk0), 0);
    check("R1 v2_out", int'(v2_0), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // driver: reference stimulus plus an independent loop model
  task automatic run_phase(input int inst, input int m, input int n_init,
                           input int p, input int rises);
    int n = n_init;
    int streak = 0;
    do_reset();
    for (int r = 1; r <= rises; r++) begin
      item_t it;
      int hi;
      string tag;
      ref_in = 1'b1;
      tag = "R2";
      if (r >= 3 && (r % 2) == 1) begin
        int nn;
        if (m * n < p) begin
          nn  = (n >= 255) ? n : n + 1;
          tag = (nn == n) ? "R9 early" : "R6";
        end else if (m * n > p) begin
          nn  = (n <= 1) ? n : n - 1;
          tag = (nn == n) ? "R9 late" : "R7";
        end else begin
          nn  = n;
          tag = "R8";
        end
        if (nn == n) streak = (streak < 4) ? streak + 1 : 4;
        else         streak = 0;
        n = nn;
      end
      it.due  = cyc + 3;
      it.inst = inst;
      it.n    = n;
      it.lk   = (streak == 4);
      it.tag  = tag;
      sb.push_back(it);
      hi = (p / 2 > 0) ? p / 2 : 1;
      repeat (hi) @(negedge clk);
      ref_in = 1'b0;
      repeat (p - hi) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // early pull-in: M*N=64 < 80, settles at N=20 then locks (R6, R8, R10)
    run_phase(0, 4, 16, 80, 17);
    check("R3 R4 R5 v2 gap at lock", last_gap, 80);
    // late pull-in: M*N=64 > 48, settles at N=12 (R7, R8)
    run_phase(0, 4, 16, 48, 17);
    check("R3 R4 R5 v2 gap at lock", last_gap, 48);
    // upper rail: 2*254 < 600 -> 255, then saturated (R9)
    run_phase(1, 2, 254, 600, 11);
    // lower rail: 4*2 > 3 -> 1, then saturated (R9)
    run_phase(2, 4, 2, 3, 11);
    wait (sb.size() == 0);
    finish_run();
  end
endmodule